// File: doc/BRIEF.md
# Edge-Selectable Interrupt Request Controller

This block collects interrupt events for a small 8-bit controller and presents them to the CPU as a single interrupt line. Three external pins (two counter inputs and one general interrupt pin) are synchronized. Each pin is then watched for an edge whose direction software picks per pin. Three internal peripherals (timer 1, serial port 2, key input) deliver one-cycle pulses. A seventh source is shared by two conversion events: a key-triggered conversion start and a conversion-complete signal. A select bit decides which of the two feeds the shared request.

Every event latches a request bit whether or not that source is enabled. The interrupt line is raised when any request meets its enable bit and the CPU-side disable input is low. The edge detector compares the current pin level against the selected polarity. A polarity change on a pin that does not move can therefore latch a request, in the same way a real edge would. Switching the conversion select onto a source that is already high behaves the same way. Software should disable the source, make the change, clear the request and then enable it again. Registers are reached over a synchronous byte bus. The interrupt handler clears the request it serves through a separate acknowledge input.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the request, enable, polarity and conversion-select registers read 0x00 and irq_o is low.
- R2: With a pin's polarity bit at 0, a falling edge on that pin sets its request bit three clock edges after the pin changes, and a rising edge sets nothing. Pin 0 maps to request bit 0, pin 1 to bit 1 and pin 2 to bit 3.
- R3: With a pin's polarity bit at 1, a rising edge sets its request bit and a falling edge sets nothing.
- R4: With a pin held still, changing its polarity bit sets its request bit exactly when the pin is high and the new polarity is 1, or when the pin is low and the new polarity is 0. Writing an unchanged polarity sets nothing.
- R5: A one-cycle pulse on tmr1_evt_i, sio2_evt_i or key_evt_i sets request bit 2, 4 or 5 respectively at the next clock edge.
- R6: Request bit 6 is set on a rising edge of the selected conversion source. The select bit (bit 6 at the select address) chooses cnv_key_i when 0 and cnv_done_i when 1, and the unselected source has no effect. Switching the select onto a source that is already high sets bit 6.
- R7: A bus write to the request register clears every bit written as 0 and leaves every bit written as 1 unchanged. Software cannot set a request.
- R8: A hardware event that sets a request bit wins over a write of 0 or an acknowledge of that bit in the same cycle.
- R9: A disabled source still latches its request. irq_o is high exactly when some request bit and its enable bit are both 1 and cpu_idis_i is 0.
- R10: Bit 7 of the request and enable registers always reads 0, and writing 1 to enable bit 7 changes nothing.
- R11: A one-cycle acknowledge with ack_id_i = k (0 to 6) clears request bit k. ack_id_i = 7 clears nothing.
- R12: Register addresses default to request 0x10, enable 0x11, polarity 0x12 (bits 0 to 2 for pins 0 to 2) and select 0x13 (bit 6). Unused bits read 0, and only a write to the enable address changes the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 3 | Asynchronous external pins: counter 0, counter 1, general interrupt |
| tmr1_evt_i | input | 1 | Timer 1 event pulse |
| sio2_evt_i | input | 1 | Serial port 2 event pulse |
| key_evt_i | input | 1 | Key input event pulse |
| cnv_key_i | input | 1 | Key-triggered conversion event |
| cnv_done_i | input | 1 | Conversion-complete event |
| cpu_idis_i | input | 1 | CPU interrupt-disable flag; 1 blocks irq_o |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | 3 | Index of the request bit being acknowledged |
| bus_addr_i | input | 8 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A hardware set and a software clear of the same request bit can fall in the same clock cycle. The clear can come as a bus write of 0 or as an acknowledge. The bench provokes this by raising a timer or serial pulse on the same negative edge where it drives a request-register write of 0x00 and an acknowledge of that bit. It then reads the request register back and expects the pulsed bit alone to remain set, while every other previously set bit is gone. A second collision, between a polarity write and a static pin level, is swept over all pins, levels and old and new polarities.

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl #(
  parameter int AW     = 8,
  parameter int SYNC   = 2,
  parameter int A_REQ  = 'h10,
  parameter int A_EN   = 'h11,
  parameter int A_POL  = 'h12,
  parameter int A_SEL  = 'h13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    pin_i,
  input  logic          tmr1_evt_i,
  input  logic          sio2_evt_i,
  input  logic          key_evt_i,
  input  logic          cnv_key_i,
  input  logic          cnv_done_i,
  input  logic          cpu_idis_i,
  input  logic          ack_i,
  input  logic [2:0]    ack_id_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  output logic          irq_o
);
  localparam int NSRC = 7;
  localparam int NPIN = 3;

  logic [SYNC*NPIN-1:0] sync_q;
  logic [NPIN-1:0] pin_s, lvl, lvl_q, pin_ev, pol_q;
  logic            sel_q, cnv_mux, cnv_q, cnv_rise;
  logic [NSRC-1:0] req_q, en_q, set_v, clr_v, ack_v;
  logic            hit_req, hit_en, hit_pol, hit_sel;

  assign hit_req = bus_addr_i == AW'(A_REQ);
  assign hit_en  = bus_addr_i == AW'(A_EN);
  assign hit_pol = bus_addr_i == AW'(A_POL);
  assign hit_sel = bus_addr_i == AW'(A_SEL);

  // active edge always appears as a rise of lvl
  assign pin_s  = sync_q[SYNC*NPIN-1 -: NPIN];
  assign lvl    = pin_s ~^ pol_q;
  assign pin_ev = lvl & ~lvl_q;

  assign cnv_mux  = sel_q ? cnv_done_i : cnv_key_i;
  assign cnv_rise = cnv_mux & ~cnv_q;

  assign set_v = {cnv_rise, key_evt_i, sio2_evt_i, pin_ev[2],
                  tmr1_evt_i, pin_ev[1], pin_ev[0]};
  assign ack_v = ack_i ? (NSRC'(1) << ack_id_i) : '0;
  assign clr_v = ((bus_we_i && hit_req) ? ~bus_wdata_i[NSRC-1:0] : '0) | ack_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= '1;
      cnv_q  <= 1'b0;
      pol_q  <= '0;
      sel_q  <= 1'b0;
      req_q  <= '0;
      en_q   <= '0;
    end else begin
      sync_q <= {sync_q[(SYNC-1)*NPIN-1:0], pin_i};
      lvl_q  <= lvl;
      cnv_q  <= cnv_mux;
      req_q  <= (req_q & ~clr_v) | set_v;
      if (bus_we_i && hit_en)  en_q  <= bus_wdata_i[NSRC-1:0];
      if (bus_we_i && hit_pol) pol_q <= bus_wdata_i[NPIN-1:0];
      if (bus_we_i && hit_sel) sel_q <= bus_wdata_i[6];
    end
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    if (hit_req)      bus_rdata_o = {1'b0, req_q};
    else if (hit_en)  bus_rdata_o = {1'b0, en_q};
    else if (hit_pol) bus_rdata_o = {5'b0, pol_q};
    else if (hit_sel) bus_rdata_o = {1'b0, sel_q, 6'b0};
  end

  assign irq_o = (|(req_q & en_q)) & ~cpu_idis_i;
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk #(
  parameter int AW    = 8,
  parameter int A_REQ = 'h10,
  parameter int A_EN  = 'h11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr1_evt_i,
  input logic          sio2_evt_i,
  input logic          cpu_idis_i,
  input logic          irq_o,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_we_i,
  input logic [7:0]    bus_rdata_o,
  input logic [6:0]    req_q,
  input logic [6:0]    en_q
);
  AST_IDIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) cpu_idis_i |-> !irq_o); // R9
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == AW'(A_REQ) || bus_addr_i == AW'(A_EN)) |-> !bus_rdata_o[7]); // R10
  AST_TMR1_WINS: assert property (@(posedge clk) disable iff (!rst_n) tmr1_evt_i |=> req_q[2]); // R8
  AST_SIO2_WINS: assert property (@(posedge clk) disable iff (!rst_n) sio2_evt_i |=> req_q[4]); // R8
  AST_TMR1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q[2]) |-> $past(tmr1_evt_i)); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we_i && bus_addr_i == AW'(A_EN)) |=> $stable(en_q)); // R12
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(.AW(AW), .A_REQ(A_REQ), .A_EN(A_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr1_evt_i(tmr1_evt_i), .sio2_evt_i(sio2_evt_i),
  .cpu_idis_i(cpu_idis_i), .irq_o(irq_o), .bus_addr_i(bus_addr_i),
  .bus_we_i(bus_we_i), .bus_rdata_o(bus_rdata_o), .req_q(req_q), .en_q(en_q)
);

// File: tb/irq_edge_ctrl_tb.sv
`timescale 1ns/1ps
module irq_edge_ctrl_tb_top;
  localparam logic [7:0] A_REQ = 8'h10, A_EN = 8'h11, A_POL = 8'h12, A_SEL = 8'h13;

  logic clk = 0, rst_n = 0;
  logic [2:0] pin = 0, ack_id = 0;
  logic tmr1 = 0, sio2 = 0, key = 0, ckey = 0, cdone = 0, idis = 0, ack = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic we = 0, irq;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .tmr1_evt_i(tmr1), .sio2_evt_i(sio2),
    .key_evt_i(key), .cnv_key_i(ckey), .cnv_done_i(cdone), .cpu_idis_i(idis),
    .ack_i(ack), .ack_id_i(ack_id), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", r, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_all();
    wr(A_SEL, 8'h00);
    wr(A_POL, 8'h07);
    wr(A_POL, 8'h00);
    @(negedge clk); tmr1 = 1; sio2 = 1; key = 1; ckey = 1;
    @(negedge clk); tmr1 = 0; sio2 = 0; key = 0; ckey = 0;
    idle(2);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] pat;
    int bi;
    idle(3); rst_n = 1; idle(2);

    rd(A_REQ, v); chk("R1 req", v, 8'h00);
    rd(A_EN, v);  chk("R1 en", v, 8'h00);
    rd(A_POL, v); chk("R1 pol", v, 8'h00);
    rd(A_SEL, v); chk("R1 sel", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 / R3: edge sweep
    for (int p = 0; p < 3; p++)
      for (int pol = 0; pol < 2; pol++)
        for (int st = 0; st < 2; st++) begin
          bi = (p == 2) ? 3 : p;
          wr(A_POL, 8'(pol << p));
          @(negedge clk); pin[p] = st[0];
          idle(5); wr(A_REQ, 8'h00);
          @(negedge clk); pin[p] = ~st[0];
          idle(5);
          rd(A_REQ, v);
          chk(pol ? "R3 rising sel" : "R2 falling sel", v,
              (pol == (1 - st)) ? 8'(1 << bi) : 8'h00);
          @(negedge clk); pin[p] = 0; idle(5);
        end

    // R4: polarity change on a still pin
    for (int p = 0; p < 3; p++)
      for (int lv = 0; lv < 2; lv++)
        for (int op = 0; op < 2; op++)
          for (int np = 0; np < 2; np++) begin
            bi = (p == 2) ? 3 : p;
            wr(A_POL, 8'(op << p));
            @(negedge clk); pin[p] = lv[0];
            idle(5); wr(A_REQ, 8'h00);
            wr(A_POL, 8'(np << p));
            idle(3);
            rd(A_REQ, v);
            chk("R4 polarity switch", v,
                (op != np && np == lv) ? 8'(1 << bi) : 8'h00);
            wr(A_POL, 8'h00);
            @(negedge clk); pin[p] = 0; idle(5);
          end
    wr(A_REQ, 8'h00);

    // R5: internal pulses
    for (int s = 0; s < 3; s++) begin
      wr(A_REQ, 8'h00);
      @(negedge clk); tmr1 = (s == 0); sio2 = (s == 1); key = (s == 2);
      @(negedge clk); tmr1 = 0; sio2 = 0; key = 0;
      rd(A_REQ, v);
      chk("R5 pulse", v, (s == 0) ? 8'h04 : (s == 1) ? 8'h10 : 8'h20);
    end

    // R6: conversion source select
    for (int sel = 0; sel < 2; sel++)
      for (int src = 0; src < 2; src++) begin
        wr(A_SEL, 8'(sel << 6));
        wr(A_REQ, 8'h00);
        @(negedge clk); if (src) cdone = 1; else ckey = 1;
        @(negedge clk); cdone = 0; ckey = 0;
        idle(1);
        rd(A_REQ, v);
        chk("R6 conversion source", v, (sel == src) ? 8'h40 : 8'h00);
      end
    wr(A_SEL, 8'h00);
    @(negedge clk); cdone = 1;
    idle(2); wr(A_REQ, 8'h00);
    wr(A_SEL, 8'h40);
    idle(1); rd(A_REQ, v); chk("R6 select switch onto high", v, 8'h40);
    @(negedge clk); cdone = 0;
    wr(A_SEL, 8'h00); idle(1); wr(A_REQ, 8'h00);
    rd(A_SEL, v); chk("R12 select readback", v, 8'h00);

    // R7: write clears only zeros
    for (int i = 0; i < 8; i++)
      for (int inv = 0; inv < 2; inv++) begin
        pat = inv ? ~(8'h01 << i) : (8'h01 << i);
        set_all();
        wr(A_REQ, pat);
        rd(A_REQ, v);
        chk("R7 write clear", v, 8'h7F & pat);
      end

    // R8: hardware set vs clear in one cycle
    set_all();
    @(negedge clk); addr = A_REQ; wdata = 8'h00; we = 1; tmr1 = 1; ack = 1; ack_id = 2;
    @(negedge clk); we = 0; tmr1 = 0; ack = 0;
    rd(A_REQ, v); chk("R8 set wins timer", v, 8'h04);
    set_all();
    @(negedge clk); addr = A_REQ; wdata = 8'h00; we = 1; sio2 = 1; ack = 1; ack_id = 4;
    @(negedge clk); we = 0; sio2 = 0; ack = 0;
    rd(A_REQ, v); chk("R8 set wins serial", v, 8'h10);

    // R9: masking and irq
    wr(A_EN, 8'h00); set_all();
    rd(A_REQ, v); chk("R9 masked latch", v, 8'h7F);
    chk("R9 irq all masked", {7'b0, irq}, 8'h00);
    for (int k = 0; k < 7; k++)
      for (int d = 0; d < 2; d++) begin
        wr(A_EN, 8'(1 << k));
        @(negedge clk); idis = d[0]; #1;
        chk("R9 irq gate", {7'b0, irq}, d ? 8'h00 : 8'h01);
        wr(A_REQ, ~8'(1 << k));
        #1 chk("R9 irq other bits only", {7'b0, irq}, 8'h00);
        set_all();
      end
    @(negedge clk); idis = 0;

    // R10
    wr(A_EN, 8'hFF);
    rd(A_EN, v); chk("R10 enable bit7", v, 8'h7F);
    wr(A_REQ, 8'hFF);
    rd(A_REQ, v); chk("R10 request bit7", v, 8'h7F);
    wr(A_POL, 8'h00);
    rd(A_EN, v); chk("R12 enable untouched", v, 8'h7F);
    wr(A_EN, 8'h00);

    // R11: acknowledge
    for (int k = 0; k < 8; k++) begin
      set_all();
      @(negedge clk); ack = 1; ack_id = 3'(k);
      @(negedge clk); ack = 0;
      rd(A_REQ, v);
      chk("R11 ack", v, 8'h7F & ~(8'h01 << k));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule